// File: doc/BRIEF.md
# Streaming histogram with ping-pong banks

The block builds a histogram of an incoming sample stream. Each valid sample carries a bin number. The block reads that bin's count from on-chip memory, adds one and writes the new count back to the same bin. Counts stop at the largest value the count width can hold and never wrap to zero.

The memory is split into two banks. A sync pulse on the stream swaps them. One bank collects counts for the current sync period. At the same time, an external reader reads the histogram of the previous period from the other bank, one bin per cycle, with one cycle of read latency.

The update pipeline keeps separate bank bits on its read bus and its write bus, because the write-back trails the read. The data returned to the update logic is selected by the read bank bit delayed one clock. A read and a write to the same bin in the same cycle are arbitrated with the write first, and its value is forwarded, so back-to-back hits on one bin are all counted. A bank is not cleared when it becomes the collecting bank again. New counts add to what it already holds.

Top module: `stream_histogram`

## Requirements
- R1: After reset the collecting bank is bank 0, `cur_bank` is 0, and every bin of both banks reads 0.
- R2: A sample with `in_valid`=1 adds exactly one to bin `in_bin` of the collecting bank. A cycle with `in_valid`=0 changes no count.
- R3: A cycle with `in_sync`=1 swaps the collecting bank, whether or not `in_valid` is set. A valid sample that carries `in_sync`=1 is counted in the new bank.
- R4: The external reader always reads the bank that is not collecting. The count of bin `ext_addr` appears on `ext_rdata` one clock after the address.
- R5: Samples for the same bin on consecutive cycles are each counted. No increment is lost to a pending write-back.
- R6: A count that has reached 2^CNT_W-1 stays at that value when its bin is hit again.
- R7: `cur_bank` shows the collecting bank. It changes in the clock after a sync pulse.
- R8: A bank that becomes the collecting bank again keeps its earlier counts, and new samples add to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample valid |
| in_bin | input | BIN_W | Bin number of the sample |
| in_sync | input | 1 | Period boundary; swaps the banks |
| ext_addr | input | BIN_W | Bin to read from the non-collecting bank |
| ext_rdata | output | CNT_W | Count of the bin addressed one clock earlier |
| cur_bank | output | 1 | Index of the collecting bank |

## Verification
A wrong bank pointer shows up as counts in the wrong bank. A full read-out of the finished bank, a few cycles after the sync pulse, then disagrees with the reference model in many bins at once. A lost forward or a wrong read-data mux shows as a single bin that is short by the number of back-to-back hits. This appears in the read-out that follows the period in which the hits occurred. A saturation fault shows a small value where 63 is expected after a long burst on one bin.

// File: rtl/hist_pkg.sv
package hist_pkg;

  // Saturating increment on a value that is at most 32 bits wide.
  function automatic logic [31:0] sat_inc(input logic [31:0] val, input logic [31:0] maxv);
    if (val >= maxv) return maxv;
    return val + 32'd1;
  endfunction

endpackage

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int AW = 4,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_nxt;

  always_comb rdata_nxt = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/hist_arb.sv
module hist_arb #(
  parameter int AW = 5,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_vld,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] fix_rdata
);
  // Write wins a same-address collision; its data replaces the stale read.
  logic          hit_nxt, hit_q;
  logic [DW-1:0] hold_nxt, hold_q;

  always_comb begin
    hit_nxt  = rd_vld && wr_vld && (rd_addr == wr_addr);
    hold_nxt = hold_q;
    if (hit_nxt) hold_nxt = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      hit_q  <= hit_nxt;
      hold_q <= hold_nxt;
    end
  end

  assign fix_rdata = hit_q ? hold_q : mem_rdata;
endmodule

// File: rtl/hist_update.sv
module hist_update #(
  parameter int AW = 5,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_vld,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rdata,
  output logic          s1_vld,
  output logic [AW-1:0] s1_addr,
  output logic [DW-1:0] wr_data
);
  localparam logic [DW-1:0] MAXC = {DW{1'b1}};

  logic          vld_nxt, vld_q;
  logic [AW-1:0] addr_nxt, addr_q;

  always_comb begin
    vld_nxt  = rd_vld;
    addr_nxt = addr_q;
    if (rd_vld) addr_nxt = rd_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_nxt;
      addr_q <= addr_nxt;
    end
  end

  assign wr_data = DW'(hist_pkg::sat_inc(32'(rdata), 32'(MAXC)));
  assign s1_vld  = vld_q;
  assign s1_addr = addr_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (wr_data != '0)); // R6
endmodule

// File: rtl/stream_histogram.sv
module stream_histogram #(
  parameter int BIN_W = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BIN_W-1:0] in_bin,
  input  logic             in_sync,
  input  logic [BIN_W-1:0] ext_addr,
  output logic [CNT_W-1:0] ext_rdata,
  output logic             cur_bank
);
  localparam int AW = BIN_W + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // read-bus bank pointer and its delayed copy for the read-data mux
  logic ptr_q, ptr_nxt, rd_bank, rd_bank_q;
  always_comb begin
    ptr_nxt = ptr_q;
    if (in_sync) ptr_nxt = ~ptr_q;
  end
  assign rd_bank = ptr_nxt;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ptr_q     <= 1'b0;
      rd_bank_q <= 1'b0;
    end else begin
      ptr_q     <= ptr_nxt;
      rd_bank_q <= rd_bank;
    end
  end

  logic [AW-1:0]    rd_addr;
  logic             s1_vld;
  logic [AW-1:0]    s1_addr;
  logic [CNT_W-1:0] wr_data;
  logic [CNT_W-1:0] upd_rdata;
  logic [CNT_W-1:0] bank_rd [2];
  logic [1:0]       bank_we;
  logic             wr_bank;

  assign rd_addr = {rd_bank, in_bin};
  assign wr_bank = s1_addr[AW-1];

  hist_update #(.AW(AW), .DW(CNT_W)) u_upd (
    .clk(clk), .rst_n(rst_s), .rd_vld(in_valid), .rd_addr(rd_addr),
    .rdata(upd_rdata), .s1_vld(s1_vld), .s1_addr(s1_addr), .wr_data(wr_data)
  );

  hist_arb #(.AW(AW), .DW(CNT_W)) u_arb (
    .clk(clk), .rst_n(rst_s), .rd_vld(in_valid), .rd_addr(rd_addr),
    .wr_vld(s1_vld), .wr_addr(s1_addr), .wr_data(wr_data),
    .mem_rdata(bank_rd[rd_bank_q]), .fix_rdata(upd_rdata)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [BIN_W-1:0] raddr;
    assign bank_we[g] = s1_vld && (wr_bank == 1'(g));
    assign raddr      = (rd_bank == 1'(g)) ? in_bin : ext_addr;
    hist_bank #(.AW(BIN_W), .DW(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_s), .we(bank_we[g]), .waddr(s1_addr[BIN_W-1:0]),
      .wdata(wr_data), .raddr(raddr), .rdata(bank_rd[g])
    );
  end

  assign ext_rdata = bank_rd[~rd_bank_q];
  assign cur_bank  = ptr_q;

  AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_s)
    in_sync |=> (cur_bank != $past(cur_bank))); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !in_sync |=> $stable(cur_bank)); // R7
  AST_RD_MUX_LAG: assert property (@(posedge clk) disable iff (!rst_s)
    s1_vld |-> (rd_bank_q == wr_bank)); // R4
  AST_ONE_BANK_WR: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(bank_we)); // R2
endmodule

// File: tb/tb_stream_histogram.sv
`timescale 1ns/1ps
module tb_stream_histogram;
  localparam int BIN_W = 4;
  localparam int CNT_W = 6;
  localparam int NBIN  = 1 << BIN_W;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sync;
  logic [BIN_W-1:0] in_bin, ext_addr;
  logic [CNT_W-1:0] ext_rdata;
  logic cur_bank;

  always #2.5 clk = ~clk;

  stream_histogram #(.BIN_W(BIN_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bin(in_bin),
    .in_sync(in_sync), .ext_addr(ext_addr), .ext_rdata(ext_rdata), .cur_bank(cur_bank)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ref_cnt [2][NBIN];
  bit ref_bank = 0;

  function automatic int sat_add(int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit v, int b, bit s);
    in_valid = v; in_bin = BIN_W'(b); in_sync = s;
    if (s) ref_bank = ~ref_bank;
    if (v) ref_cnt[ref_bank][b] = sat_add(ref_cnt[ref_bank][b]);
    @(negedge clk);
    in_valid = 0; in_sync = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic read_all(string req);
    for (int b = 0; b < NBIN; b++) begin
      ext_addr = BIN_W'(b);
      @(negedge clk);
      chk(req, int'(ext_rdata), ref_cnt[~ref_bank][b]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int k = 0; k < 2; k++) for (int b = 0; b < NBIN; b++) ref_cnt[k][b] = 0;
    rst_n = 0; in_valid = 0; in_sync = 0; in_bin = '0; ext_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state, bank 1 readable and empty
    chk("R1 cur_bank", int'(cur_bank), 0);
    read_all("R1");

    // period 0 in bank 0: random samples with gaps (R2), burst on bin 9 (R5)
    for (int i = 0; i < 200; i++) cyc(bit'($urandom_range(0, 1)), int'($urandom_range(0, NBIN-1)), 0);
    for (int i = 0; i < 12; i++) cyc(1, 9, 0);
    cyc(1, 2, 0); cyc(1, 9, 0); cyc(1, 2, 0); cyc(1, 9, 0);   // R5 interleaved
    cyc(0, 0, 1);                                             // R3 idle sync
    chk("R7 cur_bank after sync", int'(cur_bank), 1);
    idle(4);
    read_all("R2 R5 period0");

    // period 1 in bank 1: saturation burst on bin 3 (R6)
    for (int i = 0; i < 70; i++) cyc(1, 3, 0);
    for (int i = 0; i < 100; i++) cyc(1, int'($urandom_range(0, NBIN-1)), 0);
    cyc(1, 5, 1);                        // R3 sample with sync goes to bank 0
    chk("R7 cur_bank back to 0", int'(cur_bank), 0);
    idle(4);
    read_all("R6 period1");
    chk("R6 bin3 saturated", ref_cnt[1][3], MAXC);

    // R8: swap again, bank 0 keeps period0 counts plus the sync sample
    cyc(0, 0, 1);
    idle(4);
    read_all("R8 R3 bank0");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule